// File: doc/BRIEF.md
# Register-Programmed Raster Timing Generator

This block produces the pixel and line timing of a progressive raster from four 32-bit control words held in an external register file. It decodes the horizontal and vertical totals, the visible width and height, a framebuffer base and line stride, and a pixel-format code. It then steps a pixel counter and a line counter, and from them derives an in-picture flag, a framebuffer byte address for the current pixel, a one-clock frame marker and simple sync strobes.

Horizontal quantities are programmed in 8-pixel characters and vertical quantities in lines, each stored as the count minus one. Base and stride are in 8-byte units. The counters run only while the control word has both the run bit and the extended-mode bit set. The blank bit hides the picture immediately and leaves the counters running. The block takes a copy of the timing words only at a frame boundary, or while it is idle, and only when it is enabled and not blanked. A word rewritten mid-frame therefore first shows on the next frame.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst is high, at the following clock hcount_o and vcount_o are 0 and active_o, frame_start_o, hsync_o and vsync_o are 0.
- R2: The counters advance only while ctrl_i bit 25 (run) and bit 24 (extended mode) are both 1. If either is 0, both counters are 0 at the next clock and active_o and frame_start_o stay 0.
- R3: A line lasts (hreg_i[8:0]+1)*8 pixel clocks, so hcount_o wraps from that value minus 1 to 0 and vcount_o then increments. A frame lasts vreg_i[10:0]+1 lines, and vcount_o wraps to 0 after the last line.
- R4: active_o is 1 exactly when hcount_o < (hreg_i[23:16]+1)*8, vcount_o <= vreg_i[26:16] and ctrl_i bit 6 (blank) is 0. Setting blank drops active_o in the same cycle, and the counters keep running.
- R5: fetch_addr_o = fbreg_i[19:0]*8 + vcount_o*fbreg_i[31:22]*8 + pixel bytes. The pixel-byte term comes from ctrl_i[10:8]: code 1 (4 bpp) gives hcount_o/2, codes 3 and 4 give hcount_o*2, code 5 gives hcount_o*3, code 6 gives hcount_o*4, and codes 0, 2 and 7 give hcount_o. The sum is taken modulo 2^ADDR_W.
- R6: A change to hreg_i, vreg_i, fbreg_i or the format code during a frame has no effect until the first pixel of the next frame.
- R7: A frame boundary passed while blank is 1 takes no new copy, and the previous geometry continues. The copy is taken at the next boundary passed with blank 0.
- R8: frame_start_o is 1 for exactly one clock, when both counters are 0 while running.
- R9: hsync_o is 1 during the last 8 pixels of each line, and vsync_o is 1 during the whole last line of each frame.
- R10: Pixel (0,0) is presented in the first cycle after the clock edge that samples run and extended mode set. Both counters are 0 in that cycle and frame_start_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hreg_i | input | 32 | Horizontal word: total chars-1 in [8:0], visible chars-1 in [23:16] |
| vreg_i | input | 32 | Vertical word: total lines-1 in [10:0], visible lines-1 in [26:16] |
| fbreg_i | input | 32 | Framebuffer word: base/8 in [19:0], stride/8 in [31:22] |
| ctrl_i | input | 32 | Control: run [25], extended mode [24], format [10:8], blank [6] |
| hcount_o | output | 12 | Pixel position within the line |
| vcount_o | output | 11 | Line position within the frame |
| active_o | output | 1 | Current pixel is inside the visible picture |
| fetch_addr_o | output | ADDR_W (26) | Framebuffer byte address of the current pixel |
| frame_start_o | output | 1 | First pixel of a frame |
| hsync_o | output | 1 | Last character of the line |
| vsync_o | output | 1 | Last line of the frame |

## Verification
The bench builds the block with its default ADDR_W of 26. That width holds the largest sum of base, stride times line and pixel bytes without wrap, so the full-scale vector (base 0xFFFFF, stride 1023) checks the address arithmetic with no truncation. Small geometries of 80 by 6 and 32 by 3 pixels keep frames short. This brings line wrap, frame wrap, mid-frame rewrites and the reload blocked by blank within a few thousand cycles.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CHAR_PX  = 8;
    localparam int CHAR_SH  = $clog2(CHAR_PX);

    localparam int HCODE_W  = 9;
    localparam int HDISP_W  = 8;
    localparam int VCODE_W  = 11;
    localparam int START_W  = 20;
    localparam int PITCH_W  = 10;
    localparam int FMT_W    = 3;

    localparam int HCNT_W   = HCODE_W + CHAR_SH;
    localparam int VCNT_W   = VCODE_W;
    localparam int PIXB_W   = HCNT_W + 2;

    localparam int H_TOT_LSB     = 0;
    localparam int H_DISP_LSB    = 16;
    localparam int V_TOT_LSB     = 0;
    localparam int V_DISP_LSB    = 16;
    localparam int FB_START_LSB  = 0;
    localparam int FB_PITCH_LSB  = 22;
    localparam int CTL_RUN_BIT   = 25;
    localparam int CTL_EXT_BIT   = 24;
    localparam int CTL_FMT_LSB   = 8;
    localparam int CTL_BLANK_BIT = 6;

    typedef enum logic [FMT_W-1:0] {
        PF_NONE  = 3'd0,
        PF_4BPP  = 3'd1,
        PF_8BPP  = 3'd2,
        PF_15BPP = 3'd3,
        PF_16BPP = 3'd4,
        PF_24BPP = 3'd5,
        PF_32BPP = 3'd6,
        PF_RSVD  = 3'd7
    } pix_fmt_e;

    typedef struct packed {
        logic [HCODE_W-1:0] htot;
        logic [HDISP_W-1:0] hdisp;
        logic [VCODE_W-1:0] vtot;
        logic [VCODE_W-1:0] vdisp;
        logic [START_W-1:0] start;
        logic [PITCH_W-1:0] pitch;
        pix_fmt_e           fmt;
    } raster_cfg_t;

    function automatic raster_cfg_t decode_regs(input logic [31:0] hr,
                                                input logic [31:0] vr,
                                                input logic [31:0] fr,
                                                input logic [31:0] cr);
        raster_cfg_t c;
        c.htot  = hr[H_TOT_LSB +: HCODE_W];
        c.hdisp = hr[H_DISP_LSB +: HDISP_W];
        c.vtot  = vr[V_TOT_LSB +: VCODE_W];
        c.vdisp = vr[V_DISP_LSB +: VCODE_W];
        c.start = fr[FB_START_LSB +: START_W];
        c.pitch = fr[FB_PITCH_LSB +: PITCH_W];
        c.fmt   = pix_fmt_e'(cr[CTL_FMT_LSB +: FMT_W]);
        return c;
    endfunction

    function automatic logic [PIXB_W-1:0] pixel_bytes(input pix_fmt_e fmt,
                                                      input logic [HCNT_W-1:0] h);
        logic [PIXB_W-1:0] hx;
        hx = {2'b00, h};
        case (fmt)
            PF_4BPP:            return hx >> 1;
            PF_15BPP, PF_16BPP: return hx << 1;
            PF_24BPP:           return (hx << 1) + hx;
            PF_32BPP:           return hx << 2;
            default:            return hx;
        endcase
    endfunction

    function automatic logic [HCNT_W-1:0] last_pixel(input logic [HCODE_W-1:0] code);
        return {code, {CHAR_SH{1'b1}}};
    endfunction

    function automatic logic [HCNT_W-1:0] visible_px(input logic [HDISP_W-1:0] code);
        logic [HDISP_W:0] chars;
        chars = {1'b0, code} + 1'b1;
        return HCNT_W'({chars, {CHAR_SH{1'b0}}});
    endfunction

endpackage

// File: rtl/raster_cfg_shadow.sv
module raster_cfg_shadow
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] hreg_i,
    input  logic [31:0] vreg_i,
    input  logic [31:0] fbreg_i,
    input  logic [31:0] ctrl_i,
    input  logic        reload_slot_i,
    output raster_cfg_t cfg_o
);

    logic load;
    logic unused_bits;

    assign load = reload_slot_i & ctrl_i[CTL_RUN_BIT] & ~ctrl_i[CTL_BLANK_BIT];

    assign unused_bits = ^{hreg_i[31:24], hreg_i[15:9], vreg_i[31:27], vreg_i[15:11],
                           fbreg_i[21:20], ctrl_i[31:26], ctrl_i[24], ctrl_i[23:11],
                           ctrl_i[7], ctrl_i[5:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (load) begin
            cfg_o <= decode_regs(hreg_i, vreg_i, fbreg_i, ctrl_i);
        end
    end

endmodule

// File: rtl/raster_scan_counters.sv
module raster_scan_counters
    import raster_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_i,
    input  logic [HCODE_W-1:0] htot_i,
    input  logic [VCODE_W-1:0] vtot_i,
    output logic [HCNT_W-1:0]  hcount_o,
    output logic [VCNT_W-1:0]  vcount_o,
    output logic               running_o,
    output logic               frame_end_o
);

    logic [HCNT_W-1:0] h_last;
    logic              line_end;

    assign h_last      = last_pixel(htot_i);
    assign line_end    = running_o && (hcount_o == h_last);
    assign frame_end_o = line_end && (vcount_o == vtot_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            running_o <= 1'b0;
            hcount_o  <= '0;
            vcount_o  <= '0;
        end else begin
            running_o <= run_i;
            if (!run_i) begin
                hcount_o <= '0;
                vcount_o <= '0;
            end else if (running_o) begin
                if (line_end) begin
                    hcount_o <= '0;
                    if (vcount_o == vtot_i) begin
                        vcount_o <= '0;
                    end else begin
                        vcount_o <= vcount_o + 1'b1;
                    end
                end else begin
                    hcount_o <= hcount_o + 1'b1;
                end
            end
        end
    end

    assert_h_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        running_o |-> (hcount_o <= h_last));

    assert_v_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        running_o |-> (vcount_o <= vtot_i));

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (hcount_o == '0 && vcount_o == '0 && !running_o));

endmodule

// File: rtl/raster_fetch_addr.sv
module raster_fetch_addr
    import raster_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic [START_W-1:0] start_i,
    input  logic [PITCH_W-1:0] pitch_i,
    input  pix_fmt_e           fmt_i,
    input  logic [HCNT_W-1:0]  hcount_i,
    input  logic [VCNT_W-1:0]  vcount_i,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam int FULL_W = VCNT_W + PITCH_W + CHAR_SH + 1;

    logic [FULL_W-1:0] base_b;
    logic [FULL_W-1:0] stride_b;
    logic [FULL_W-1:0] line_b;
    logic [FULL_W-1:0] pix_b;
    logic [FULL_W-1:0] full;

    assign base_b   = FULL_W'({start_i, {CHAR_SH{1'b0}}});
    assign stride_b = FULL_W'({pitch_i, {CHAR_SH{1'b0}}});
    assign line_b   = FULL_W'(vcount_i) * stride_b;
    assign pix_b    = FULL_W'(pixel_bytes(fmt_i, hcount_i));
    assign full     = base_b + line_b + pix_b;

    generate
        if (ADDR_W > FULL_W) begin : g_wide
            assign addr_o = {{(ADDR_W-FULL_W){1'b0}}, full};
        end else if (ADDR_W == FULL_W) begin : g_exact
            assign addr_o = full;
        end else begin : g_narrow
            assign addr_o = full[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       hreg_i,
    input  logic [31:0]       vreg_i,
    input  logic [31:0]       fbreg_i,
    input  logic [31:0]       ctrl_i,
    output logic [HCNT_W-1:0] hcount_o,
    output logic [VCNT_W-1:0] vcount_o,
    output logic              active_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              frame_start_o,
    output logic              hsync_o,
    output logic              vsync_o
);

    raster_cfg_t cfg;
    logic        run;
    logic        running;
    logic        frame_end;
    logic        in_h;
    logic        in_v;

    assign run = ctrl_i[CTL_RUN_BIT] & ctrl_i[CTL_EXT_BIT];

    raster_cfg_shadow u_shadow (
        .clk           (clk),
        .rst           (rst),
        .hreg_i        (hreg_i),
        .vreg_i        (vreg_i),
        .fbreg_i       (fbreg_i),
        .ctrl_i        (ctrl_i),
        .reload_slot_i (!running || frame_end),
        .cfg_o         (cfg)
    );

    raster_scan_counters u_count (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .htot_i      (cfg.htot),
        .vtot_i      (cfg.vtot),
        .hcount_o    (hcount_o),
        .vcount_o    (vcount_o),
        .running_o   (running),
        .frame_end_o (frame_end)
    );

    raster_fetch_addr #(.ADDR_W(ADDR_W)) u_addr (
        .start_i  (cfg.start),
        .pitch_i  (cfg.pitch),
        .fmt_i    (cfg.fmt),
        .hcount_i (hcount_o),
        .vcount_i (vcount_o),
        .addr_o   (fetch_addr_o)
    );

    assign in_h          = hcount_o < visible_px(cfg.hdisp);
    assign in_v          = vcount_o <= cfg.vdisp;
    assign active_o      = running && in_h && in_v && !ctrl_i[CTL_BLANK_BIT];
    assign frame_start_o = running && (hcount_o == '0) && (vcount_o == '0);
    assign hsync_o       = running && (hcount_o[HCNT_W-1:CHAR_SH] == cfg.htot);
    assign vsync_o       = running && (vcount_o == cfg.vtot);

    assert_blank_inactive_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_i[CTL_BLANK_BIT] |-> !active_o);

    assert_frame_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);

    assert_cfg_hold_mid_frame_R6: assert property (@(posedge clk) disable iff (rst)
        (running && !frame_end) |=> $stable(cfg));

endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;

    localparam int ADDR_W = 26;
    localparam int NV     = 6;
    localparam logic [31:0] RUNEXT = 32'h0300_0000;
    localparam logic [31:0] BLANK  = 32'h0000_0040;
    localparam logic [31:0] GEO_AH = 32'h0007_0009;
    localparam logic [31:0] GEO_AV = 32'h0003_0005;

    localparam logic [31:0] T_H [NV] = '{32'h0007_0009, 32'h0007_0009, 32'h0007_0009,
                                         32'h0007_0009, 32'h0007_0009, 32'h0001_0003};
    localparam logic [31:0] T_V [NV] = '{32'h0003_0005, 32'h0003_0005, 32'h0003_0005,
                                         32'h0003_0005, 32'h0003_0005, 32'h0002_0002};
    localparam logic [31:0] T_F [NV] = '{32'h0280_0010, 32'h0100_0100, 32'h0500_0003,
                                         32'h0500_0003, 32'h0500_0003, 32'hFFCF_FFFF};
    localparam int T_FMT [NV] = '{2, 1, 4, 6, 5, 3};
    localparam int T_X   [NV] = '{5, 7, 63, 64, 10, 15};
    localparam int T_Y   [NV] = '{2, 1, 3, 0, 4, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] hreg = '0, vreg = '0, fbreg = '0, ctrl = '0;
    logic [11:0] hcount;
    logic [10:0] vcount;
    logic active, frame_start, hsync, vsync;
    logic [ADDR_W-1:0] fetch_addr;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    raster_timing_gen #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .hreg_i(hreg), .vreg_i(vreg), .fbreg_i(fbreg),
        .ctrl_i(ctrl), .hcount_o(hcount), .vcount_o(vcount), .active_o(active),
        .fetch_addr_o(fetch_addr), .frame_start_o(frame_start),
        .hsync_o(hsync), .vsync_o(vsync)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_frame(input logic [31:0] h, input logic [31:0] v,
                               input logic [31:0] f, input logic [31:0] c);
        @(negedge clk);
        ctrl = '0;
        @(negedge clk);
        hreg = h; vreg = v; fbreg = f; ctrl = c;
        @(negedge clk);
    endtask

    function automatic int line_px(input logic [31:0] h);
        return (int'(h[8:0]) + 1) * 8;
    endfunction

    function automatic bit exp_active(input logic [31:0] h, input logic [31:0] v,
                                      input int x, input int y);
        return (x < (int'(h[23:16]) + 1) * 8) && (y <= int'(v[26:16]));
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] f, input int fmt,
                                             input int x, input int y);
        longint b;
        longint xb;
        case (fmt)
            1:       xb = x / 2;
            3, 4:    xb = x * 2;
            5:       xb = x * 3;
            6:       xb = x * 4;
            default: xb = x;
        endcase
        b = longint'(f[19:0]) * 8 + longint'(y) * longint'(f[31:22]) * 8 + xb;
        return 32'(b % (longint'(1) << ADDR_W));
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        adv(3);
        chk("R1 hcount in reset", 32'(hcount), 0);
        chk("R1 vcount in reset", 32'(vcount), 0);
        chk("R1 flags in reset", {28'd0, active, frame_start, hsync, vsync}, 0);
        rst = 1'b0;

        // R5 R4 R3: vector table walk
        for (int i = 0; i < NV; i++) begin
            int k;
            bit ea;
            k = T_Y[i] * line_px(T_H[i]) + T_X[i];
            start_frame(T_H[i], T_V[i], T_F[i], RUNEXT | (32'(T_FMT[i]) << 8));
            adv(k);
            ea = exp_active(T_H[i], T_V[i], T_X[i], T_Y[i]);
            chk($sformatf("R3 vec%0d hcount", i), 32'(hcount), 32'(T_X[i]));
            chk($sformatf("R3 vec%0d vcount", i), 32'(vcount), 32'(T_Y[i]));
            chk($sformatf("R4 vec%0d active", i), 32'(active), 32'(ea));
            if (ea) chk($sformatf("R5 vec%0d addr", i), 32'(fetch_addr),
                        exp_addr(T_F[i], T_FMT[i], T_X[i], T_Y[i]));
        end

        // R2: run without extended mode, then extended mode without run
        start_frame(GEO_AH, GEO_AV, 32'h0280_0010, 32'h0200_0200);
        adv(5);
        chk("R2 run only hcount", 32'(hcount), 0);
        chk("R2 run only flags", {30'd0, active, frame_start}, 0);
        ctrl = 32'h0100_0200;
        adv(3);
        chk("R2 ext only hcount", 32'(hcount), 0);

        // R10 R8: first pixel after enable
        start_frame(GEO_AH, GEO_AV, 32'h0280_0010, RUNEXT | 32'h200);
        chk("R10 first pixel h", 32'(hcount), 0);
        chk("R10 frame_start at first pixel", 32'(frame_start), 1);
        chk("R4 active at first pixel", 32'(active), 1);
        adv(1);
        chk("R8 frame_start one clock", 32'(frame_start), 0);
        chk("R10 second pixel h", 32'(hcount), 1);

        // R9 R3: line and frame boundaries (frame of 80 x 6)
        adv(70);
        chk("R9 no hsync at 71", 32'(hsync), 0);
        adv(8);
        chk("R3 last pixel h", 32'(hcount), 79);
        chk("R9 hsync at 79", 32'(hsync), 1);
        adv(1);
        chk("R3 line wrap h/v", {20'd0, hcount}, 0);
        chk("R3 line wrap v", 32'(vcount), 1);
        adv(320);
        chk("R9 vsync last line", 32'(vsync), 1);
        chk("R3 last line v", 32'(vcount), 5);
        adv(80);
        chk("R3 frame wrap v", 32'(vcount), 0);
        chk("R8 frame_start next frame", 32'(frame_start), 1);

        // R4: blank hides picture, counters keep going
        adv(1);
        ctrl = ctrl | BLANK;
        #1;
        chk("R4 blank drops active", 32'(active), 0);
        adv(1);
        chk("R4 counters run while blank", 32'(hcount), 2);
        ctrl = ctrl & ~BLANK;
        #1;
        chk("R4 active after unblank", 32'(active), 1);

        // R6: mid-frame rewrite waits for next frame
        hreg = 32'h0000_0001;
        adv(100);
        chk("R6 old geometry h", 32'(hcount), 22);
        chk("R6 old geometry v", 32'(vcount), 1);
        adv(378);
        chk("R6 boundary frame_start", 32'(frame_start), 1);
        adv(17);
        chk("R6 new geometry h", 32'(hcount), 1);
        chk("R6 new geometry v", 32'(vcount), 1);

        // R7: boundary passed while blanked keeps old geometry
        ctrl = ctrl | BLANK;
        hreg = GEO_AH;
        adv(79);
        ctrl = ctrl & ~BLANK;
        adv(16);
        chk("R7 blocked reload h", 32'(hcount), 0);
        chk("R7 blocked reload v", 32'(vcount), 1);
        adv(80);
        adv(80);
        chk("R7 later reload h", 32'(hcount), 0);
        chk("R7 later reload v", 32'(vcount), 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

endmodule